// File: doc/BRIEF.md
# NAND ECC Geometry Calculator

This unit works out how a BCH error-correction codec should split a NAND page. Given the page data size and the spare-area size in bytes, it picks the ECC chunk size, counts the chunks, derives the correction strength from the spare space left after a fixed 10-byte metadata area, and finds where the physical bad-block marker lands once the codec has interleaved parity bits between the data chunks. The codec uses 13-bit Galois-field symbols (`GF_LEN`).

A request is presented on a valid/ready pair. `in_ready` is high only while the unit is idle. A request is taken on a clock edge where `in_valid` and `in_ready` are both high. While a calculation is running, `in_ready` stays low and `in_valid` has no effect. There is no back-pressure on the result. `done` pulses for one cycle and the registered geometry outputs then hold their values until the next pulse. All divisions share one restoring shift-subtract divider that produces one quotient bit per clock. Geometries that cannot be supported raise `err` together with `done` and force every geometry output to zero.

Top module: `nandgeo_calc`

## Requirements
- R1: `in_ready` is high only in the idle state. A request is captured when `in_valid` and `in_ready` are high at a clock edge. `in_ready` is low from the next cycle until the result is delivered, and `in_valid` (with any page or spare values) during that time does not change the result.
- R2: `done` is high for exactly one cycle per accepted request. All geometry outputs and `err` keep their values on every cycle where `done` is low.
- R3: `chunk_size` is the smallest power of two, from 512 up to 2^`CHUNK_MAX_LOG2` (default 2048), that is not smaller than the spare size.
- R4: `chunk_count` equals page size divided by `chunk_size`, with the remainder discarded.
- R5: `strength` is ((spare − 10) × 8) / (`GF_LEN` × `chunk_count`), rounded down to an even value and then limited to `MAX_STRENGTH` (default 40, which must be even).
- R6: With P = page × 8 − 80, D = `chunk_size` × 8 and E = `strength` × `GF_LEN`, let k = P / (D + E). The marker position is P − k × E. `mark_byte` is that position divided by 8, and `mark_bit` is its low three bits.
- R7: `err` is raised with `done`, and all geometry outputs are zero, when any of these holds: the spare size exceeds the largest chunk, the spare size is below 10, the page is smaller than the chunk, or the position of P inside its chunk (P − k × (D + E)) exceeds D, which would put the marker inside parity.
- R8: After reset, `in_ready` is 1, `done` and `err` are 0, and every geometry output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit idle and able to take a request |
| page_bytes | input | PAGE_W | Page data size in bytes |
| spare_bytes | input | SPARE_W | Spare-area size in bytes |
| done | output | 1 | One-cycle result strobe |
| err | output | 1 | Unsupported geometry |
| chunk_size | output | CHUNK_MAX_LOG2+1 | ECC chunk size in bytes |
| chunk_count | output | PAGE_W | Chunks per page |
| strength | output | clog2(MAX_STRENGTH+1) | Correction strength |
| mark_byte | output | PAGE_W | Marker byte offset in the ECC page view |
| mark_bit | output | 3 | Marker bit offset within that byte |

## Verification
The assertions take for granted that the parameters keep `MAX_STRENGTH` even. They also assume that the size checks always run before a division, so the divider never sees a zero divisor. The divider identity they check relies on the operands staying fixed while a division runs, which holds because the operands come only from captured registers and never from the live inputs. The stimulus changes `page_bytes` and `spare_bytes` only at falling edges. It drives deliberately different values while the unit is busy, so that only the captured request can affect the result. It keeps page sizes within 16 bits, so that page × 8 fits the divider width.

// File: rtl/nandgeo_pkg.sv
package nandgeo_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SIZE,
    ST_STR_GO,
    ST_STR_RUN,
    ST_MARK_GO,
    ST_MARK_RUN
  } geo_state_e;
endpackage

// File: rtl/nandgeo_chunk_sizer.sv
// Picks the smallest power-of-two chunk that covers the spare area.
module nandgeo_chunk_sizer #(
  parameter int SPARE_W  = 16,
  parameter int MIN_LOG2 = 9,
  parameter int MAX_LOG2 = 11,
  parameter int CL_W     = 4
) (
  input  logic [SPARE_W-1:0] spare,
  output logic [CL_W-1:0]    chunk_log2,
  output logic               too_big
);
  localparam int N = MAX_LOG2 - MIN_LOG2 + 1;

  logic [N-1:0] fits;

  for (genvar i = 0; i < N; i++) begin : g_fit
    localparam int K = MIN_LOG2 + i;
    assign fits[i] = (33'(spare) <= (33'd1 << K));
  end

  always_comb begin
    chunk_log2 = CL_W'(MAX_LOG2);
    too_big    = !fits[N-1];
    for (int j = N - 1; j >= 0; j--) begin
      if (fits[j]) chunk_log2 = CL_W'(MIN_LOG2 + j);
    end
  end
endmodule

// File: rtl/nandgeo_divider.sv
// Restoring shift-subtract divider, one quotient bit per clock.
module nandgeo_divider #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic         done,
  output logic [W-1:0] quot,
  output logic [W-1:0] rem
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  q_r, r_r, d_r;
  logic [CW-1:0] cnt;
  logic          busy;
  logic [W:0]    trial;

  assign trial = {r_r, q_r[W-1]};
  assign quot  = q_r;
  assign rem   = r_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r  <= '0;
      r_r  <= '0;
      d_r  <= '0;
      cnt  <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        q_r  <= num;
        r_r  <= '0;
        d_r  <= den;
        cnt  <= CW'(W);
        busy <= 1'b1;
      end else if (busy) begin
        if (trial >= {1'b0, d_r}) begin
          r_r <= W'(trial - {1'b0, d_r});
          q_r <= {q_r[W-2:0], 1'b1};
        end else begin
          r_r <= trial[W-1:0];
          q_r <= {q_r[W-2:0], 1'b0};
        end
        cnt <= cnt - CW'(1);
        if (cnt == CW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/nandgeo_calc.sv
module nandgeo_calc
  import nandgeo_pkg::*;
#(
  parameter int PAGE_W         = 16,
  parameter int SPARE_W        = 16,
  parameter int CHUNK_MIN_LOG2 = 9,
  parameter int CHUNK_MAX_LOG2 = 11,
  parameter int GF_LEN         = 13,
  parameter int META_BYTES     = 10,
  parameter int MAX_STRENGTH   = 40
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              in_valid,
  output logic                              in_ready,
  input  logic [PAGE_W-1:0]                 page_bytes,
  input  logic [SPARE_W-1:0]                spare_bytes,
  output logic                              done,
  output logic                              err,
  output logic [CHUNK_MAX_LOG2:0]           chunk_size,
  output logic [PAGE_W-1:0]                 chunk_count,
  output logic [$clog2(MAX_STRENGTH+1)-1:0] strength,
  output logic [PAGE_W-1:0]                 mark_byte,
  output logic [2:0]                        mark_bit
);
  localparam int WIDEST  = (PAGE_W > SPARE_W) ? PAGE_W : SPARE_W;
  localparam int DIV_W   = WIDEST + 4;
  localparam int STR_W   = $clog2(MAX_STRENGTH + 1);
  localparam int CL_W    = $clog2(CHUNK_MAX_LOG2 + 1);
  localparam int CHUNK_W = CHUNK_MAX_LOG2 + 1;

  geo_state_e         state;
  logic [PAGE_W-1:0]  page_q;
  logic [SPARE_W-1:0] spare_q;
  logic [CL_W-1:0]    clog_q;
  logic [PAGE_W-1:0]  count_q;
  logic [STR_W-1:0]   str_q;

  // sizing
  logic [CL_W-1:0]   clog_c;
  logic              too_big_c;
  logic [PAGE_W-1:0] count_c;
  logic              size_err_c;

  nandgeo_chunk_sizer #(
    .SPARE_W (SPARE_W),
    .MIN_LOG2(CHUNK_MIN_LOG2),
    .MAX_LOG2(CHUNK_MAX_LOG2),
    .CL_W    (CL_W)
  ) u_sizer (
    .spare     (spare_q),
    .chunk_log2(clog_c),
    .too_big   (too_big_c)
  );

  assign count_c    = page_q >> clog_c;
  assign size_err_c = too_big_c || (spare_q < SPARE_W'(META_BYTES)) || (count_c == '0);

  // shared divider
  logic             div_start, div_done, marking;
  logic [DIV_W-1:0] div_num, div_den, div_q, div_r;
  logic [DIV_W-1:0] num_str, den_str, num_mark, den_mark;
  logic [DIV_W-1:0] chunk_bits, parity_bits, q_even, mark_pos;
  logic [STR_W-1:0] str_next;
  logic             in_parity;

  assign num_str     = (DIV_W'(spare_q) - DIV_W'(META_BYTES)) << 3;
  assign den_str     = DIV_W'(count_q) * DIV_W'(GF_LEN);
  assign chunk_bits  = (DIV_W'(1) << clog_q) << 3;
  assign parity_bits = DIV_W'(str_q) * DIV_W'(GF_LEN);
  assign num_mark    = (DIV_W'(page_q) << 3) - DIV_W'(META_BYTES * 8);
  assign den_mark    = chunk_bits + parity_bits;

  assign marking   = (state == ST_MARK_GO) || (state == ST_MARK_RUN);
  assign div_start = (state == ST_STR_GO) || (state == ST_MARK_GO);
  assign div_num   = marking ? num_mark : num_str;
  assign div_den   = marking ? den_mark : den_str;

  nandgeo_divider #(.W(DIV_W)) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .start(div_start),
    .num  (div_num),
    .den  (div_den),
    .done (div_done),
    .quot (div_q),
    .rem  (div_r)
  );

  // strength: round down to even, then clamp
  assign q_even   = div_q & ~DIV_W'(1);
  assign str_next = (q_even > DIV_W'(MAX_STRENGTH)) ? STR_W'(MAX_STRENGTH) : STR_W'(q_even);

  // marker: P - k*E equals k*D + remainder, so no multiplier is needed
  assign mark_pos  = ((div_q << clog_q) << 3) + div_r;
  assign in_parity = div_r > chunk_bits;

  assign in_ready = (state == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      page_q      <= '0;
      spare_q     <= '0;
      clog_q      <= '0;
      count_q     <= '0;
      str_q       <= '0;
      done        <= 1'b0;
      err         <= 1'b0;
      chunk_size  <= '0;
      chunk_count <= '0;
      strength    <= '0;
      mark_byte   <= '0;
      mark_bit    <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (in_valid) begin
            page_q  <= page_bytes;
            spare_q <= spare_bytes;
            state   <= ST_SIZE;
          end
        end
        ST_SIZE: begin
          clog_q  <= clog_c;
          count_q <= count_c;
          if (size_err_c) begin
            done        <= 1'b1;
            err         <= 1'b1;
            chunk_size  <= '0;
            chunk_count <= '0;
            strength    <= '0;
            mark_byte   <= '0;
            mark_bit    <= '0;
            state       <= ST_IDLE;
          end else begin
            state <= ST_STR_GO;
          end
        end
        ST_STR_GO: state <= ST_STR_RUN;
        ST_STR_RUN: begin
          if (div_done) begin
            str_q <= str_next;
            state <= ST_MARK_GO;
          end
        end
        ST_MARK_GO: state <= ST_MARK_RUN;
        ST_MARK_RUN: begin
          if (div_done) begin
            done  <= 1'b1;
            state <= ST_IDLE;
            if (in_parity) begin
              err         <= 1'b1;
              chunk_size  <= '0;
              chunk_count <= '0;
              strength    <= '0;
              mark_byte   <= '0;
              mark_bit    <= '0;
            end else begin
              err         <= 1'b0;
              chunk_size  <= CHUNK_W'(1) << clog_q;
              chunk_count <= count_q;
              strength    <= str_q;
              mark_byte   <= PAGE_W'(mark_pos >> 3);
              mark_bit    <= mark_pos[2:0];
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nandgeo_calc_chk.sv
module nandgeo_calc_chk #(
  parameter int PAGE_W         = 16,
  parameter int DIV_W          = 20,
  parameter int STR_W          = 6,
  parameter int CHUNK_W        = 12,
  parameter int CHUNK_MIN_LOG2 = 9,
  parameter int MAX_STRENGTH   = 40
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic               done,
  input logic               err,
  input logic [CHUNK_W-1:0] chunk_size,
  input logic [PAGE_W-1:0]  chunk_count,
  input logic [STR_W-1:0]   strength,
  input logic [PAGE_W-1:0]  mark_byte,
  input logic [2:0]         mark_bit,
  input logic               div_done,
  input logic [DIV_W-1:0]   div_num,
  input logic [DIV_W-1:0]   div_den,
  input logic [DIV_W-1:0]   div_q,
  input logic [DIV_W-1:0]   div_r
);
  localparam int W2 = 2 * DIV_W;

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready); // R1
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R2
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(err) && $stable(chunk_size) && $stable(chunk_count) && $stable(strength) && $stable(mark_byte) && $stable(mark_bit))); // R2
  AST_CHUNK_POW2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> ($onehot(chunk_size) && chunk_size >= (CHUNK_W'(1) << CHUNK_MIN_LOG2))); // R3
  AST_STR_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> (!strength[0] && strength <= STR_W'(MAX_STRENGTH))); // R5
  AST_DIV_IDENTITY: assert property (@(posedge clk) disable iff (!rst_n)
    div_done |-> ((W2'(div_q) * W2'(div_den) + W2'(div_r) == W2'(div_num)) && div_r < div_den)); // R6
  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> (chunk_size == '0 && chunk_count == '0 && strength == '0 && mark_byte == '0 && mark_bit == '0)); // R7
endmodule

bind nandgeo_calc nandgeo_calc_chk #(
  .PAGE_W        (PAGE_W),
  .DIV_W         (DIV_W),
  .STR_W         (STR_W),
  .CHUNK_W       (CHUNK_W),
  .CHUNK_MIN_LOG2(CHUNK_MIN_LOG2),
  .MAX_STRENGTH  (MAX_STRENGTH)
) u_chk (.*);

// File: tb/nandgeo_calc_test.sv
`timescale 1ns/1ps
module nandgeo_calc_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] page_bytes = '0;
  logic [15:0] spare_bytes = '0;
  logic        done, err;
  logic [11:0] chunk_size;
  logic [15:0] chunk_count;
  logic [5:0]  strength;
  logic [15:0] mark_byte;
  logic [2:0]  mark_bit;

  always #10 clk = ~clk;

  nandgeo_calc uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .page_bytes(page_bytes), .spare_bytes(spare_bytes), .done(done), .err(err),
    .chunk_size(chunk_size), .chunk_count(chunk_count), .strength(strength),
    .mark_byte(mark_byte), .mark_bit(mark_bit)
  );

  typedef struct {
    int page; int spare; bit err;
    int csize; int cnt; int str; int mbyte; int mbit;
  } exp_t;

  exp_t sb[$];
  int   n_tests = 0;
  int   n_fail = 0;
  bit   finished = 0;

  task automatic chk(string req, string what, int act, int expv);
    n_tests++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic exp_t model(int page, int spare);
    exp_t e;
    int chunk, off, d, idx, rem;
    e.page = page; e.spare = spare; e.err = 0;
    e.csize = 0; e.cnt = 0; e.str = 0; e.mbyte = 0; e.mbit = 0;
    chunk = 512;
    while (chunk < spare && chunk < 2048) chunk = chunk * 2;
    if (spare > chunk || spare < 10) e.err = 1;
    if (!e.err) begin
      e.cnt = page / chunk;
      if (e.cnt == 0) e.err = 1;
    end
    if (!e.err) begin
      e.str = ((spare - 10) * 8) / (13 * e.cnt);
      e.str = e.str - (e.str % 2);
      if (e.str > 40) e.str = 40;
      off = page * 8 - 80;
      d   = chunk * 8 + e.str * 13;
      idx = off / d;
      rem = off - idx * d;
      if (rem > chunk * 8) e.err = 1;
      off = off - idx * e.str * 13;
      e.csize = chunk; e.mbyte = off / 8; e.mbit = off % 8;
    end
    if (e.err) begin
      e.csize = 0; e.cnt = 0; e.str = 0; e.mbyte = 0; e.mbit = 0;
    end
    return e;
  endfunction

  // driver: push expectation, then present request; optional busy-time junk
  task automatic send(int page, int spare, int hold);
    exp_t e;
    e = model(page, spare);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    sb.push_back(e);
    in_valid    = 1'b1;
    page_bytes  = 16'(page);
    spare_bytes = 16'(spare);
    @(negedge clk);
    if (hold > 0) begin
      page_bytes  = 16'd8192;
      spare_bytes = 16'd100;
      for (int i = 0; i < hold; i++) begin
        chk("R1", "in_ready while busy", int'(in_ready), 0);
        @(negedge clk);
      end
    end
    in_valid = 1'b0;
  endtask

  // monitor: compare each result with the scoreboard head
  initial begin
    exp_t e;
    int   held;
    forever begin
      @(negedge clk);
      if (rst_n && done) begin
        if (sb.size() == 0) begin
          chk("R2", "unexpected done", 1, 0);
        end else begin
          e = sb.pop_front();
          $display("[TB] result page=%0d spare=%0d", e.page, e.spare);
          chk("R7", "err", int'(err), int'(e.err));
          chk("R3", "chunk_size", int'(chunk_size), e.csize);
          chk("R4", "chunk_count", int'(chunk_count), e.cnt);
          chk("R5", "strength", int'(strength), e.str);
          chk("R6", "mark_byte", int'(mark_byte), e.mbyte);
          chk("R6", "mark_bit", int'(mark_bit), e.mbit);
          held = int'(mark_byte);
          @(negedge clk);
          chk("R2", "done width", int'(done), 0);
          chk("R2", "mark_byte hold", int'(mark_byte), held);
        end
      end
    end
  end

  task automatic report;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    chk("R8", "in_ready", int'(in_ready), 1);
    chk("R8", "done", int'(done), 0);
    chk("R8", "err", int'(err), 0);
    chk("R8", "chunk_size", int'(chunk_size), 0);
    chk("R8", "mark_byte", int'(mark_byte), 0);
    rst_n = 1'b1;
    send(2048, 64, 0);
    send(4096, 224, 8);    // R1 junk while busy
    send(8192, 448, 0);
    send(2048, 112, 0);    // R6 nonzero bit offset
    send(4096, 1024, 0);   // R5 clamp
    send(2048, 513, 5);    // R3 doubled chunk
    send(512, 16, 0);      // R4 single chunk
    send(2048, 10, 0);     // R5 zero strength
    send(65535, 64, 0);    // R4 truncating count
    send(2048, 4096, 0);   // R7 spare beyond largest chunk
    send(2048, 8, 0);      // R7 spare below metadata
    send(256, 16, 0);      // R7 page smaller than chunk
    send(2048, 64, 3);     // R2 repeated after errors
    while (sb.size() != 0) @(negedge clk);
    repeat (5) @(negedge clk);
    chk("R1", "in_ready after drain", int'(in_ready), 1);
    finished = 1;
    report();
  end
endmodule